// File: doc/BRIEF.md
# UDP Port Stream Demultiplexer

This block sits behind an Ethernet receive path and steers whole received frames to one of several streaming outputs or to a catch-all control output. Frames enter on a 32-bit word stream with start-of-frame, end-of-frame and valid markers. The block finds the IPv4/UDP headers inside the frame and compares the UDP destination port with a small table of programmable entries. Each entry holds a 16-bit port number and an enable bit. A frame that matches an enabled entry leaves on that entry's streaming output. Every other frame leaves on the control output.

Words are packed big-endian, so the first byte of the destination MAC address sits in bits [31:24] of word 0. Every accepted word is held in a small FIFO until the routing decision for its frame is known. The FIFO then replays the frame, unchanged, to the chosen output. Each output has its own ready signal for backpressure.

A simple memory-mapped port gives read and write access to the port table. Each entry occupies one word address, counting up from address 0.

Top module: `udp_stream_demux`

## Requirements
- R1: After reset, no output valid is asserted, `s_ready` is high, and every table entry reads as zero.
- R2: Table entry i sits at word address i, for i from 0 to NUM_CH-1. Bits [15:0] hold the port number and bit 16 holds the enable. Writes store only these 17 bits, and bits [31:17] always read as zero. Addresses at or above NUM_CH read as zero, and writes to them change nothing. Read data appears in the cycle after `mm_rd`.
- R3: A frame is UDP-eligible when all three of these hold:
  - word 3 bits [31:16] equal 0x0800;
  - word 3 bits [15:8] equal 0x45;
  - word 5 bits [7:0] equal 17.

  A UDP-eligible frame whose destination port (word 9 bits [31:16]) equals the port of an enabled entry i goes to output i, on `m_valid[i]`.
- R4: Every other frame goes to the control output, `m_valid[NUM_CH]`. This includes non-IPv4 frames, non-UDP frames, frames with other header-length bytes, frames that match only disabled entries, and frames shorter than 10 words.
- R5: When several enabled entries hold the same port number, the lowest-indexed entry receives the frame.
- R6: Each frame leaves on a single output, with its words in their original order and its data, start and end markers unchanged. Frames on the same output keep their arrival order.
- R7: An output whose ready is low holds its valid, data and markers unchanged. No word is lost. When all outputs are stalled, the block accepts exactly FIFO_DEPTH+1 words of a routable frame and then holds `s_ready` low.
- R8: The routing of a frame uses the table contents at the moment its first word is accepted. A write that lands while the frame is in flight affects only later frames.
- R9: At most one bit of `m_valid` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 32 | Input frame word |
| s_sop | input | 1 | First word of a frame |
| s_eop | input | 1 | Last word of a frame |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can accept a word |
| m_data | output | 32 | Output word, shared by all outputs |
| m_sop | output | 1 | Output first-word marker |
| m_eop | output | 1 | Output last-word marker |
| m_valid | output | NUM_CH+1 | Per-output valid; bit NUM_CH is the control output |
| m_ready | input | NUM_CH+1 | Per-output ready |
| mm_addr | input | MM_ADDR_W | Register word address |
| mm_wr | input | 1 | Register write strobe |
| mm_wdata | input | 32 | Register write data |
| mm_rd | input | 1 | Register read strobe |
| mm_rdata | output | 32 | Register read data, one cycle after the strobe |

## Verification
The bench sends frames that sit on the edges of the decision:
- a 9-word UDP frame whose port would match, which must fall to control, next to a 10-word frame that must not;
- duplicate enabled ports, where a design that got the priority wrong would pick the higher index;
- disabled entries, wrong header-length bytes and non-UDP protocols.

A table write is made in the middle of a frame, in both directions. A design that read the live table at the port word would send such a frame to the wrong place. All outputs are stalled while a long frame arrives, and the count of accepted words shows whether the FIFO either dropped words or overran. Random per-output ready patterns catch outputs that change data while stalled, and frames that are split or reordered across outputs.

// File: rtl/udp_demux_pkg.sv
package udp_demux_pkg;
  localparam int WORD_W = 32;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  VER_IHL_PLAIN = 8'h45;
  localparam logic [7:0]  PROTO_UDP = 8'd17;
  localparam int ETYPE_WORD = 3;
  localparam int PROTO_WORD = 5;
  localparam int PORT_WORD  = 9;

  typedef struct packed {
    logic        en;
    logic [15:0] port;
  } port_entry_t;
endpackage

// File: rtl/udp_demux_fifo.sv
module udp_demux_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, rptr_q;

  always_ff @(posedge clk) begin
    if (wr) mem[wptr_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr) wptr_q <= wptr_q + 1'b1;
      if (rd) rptr_q <= rptr_q + 1'b1;
    end
  end

  assign rdata = mem[rptr_q[AW-1:0]];
  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[AW-1:0] == rptr_q[AW-1:0]) && (wptr_q[AW] != rptr_q[AW]);

  // R7
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst) wr |-> !full);
  // R7
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst) rd |-> !empty);
endmodule

// File: rtl/udp_demux_regs.sv
module udp_demux_regs
  import udp_demux_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int MM_ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [MM_ADDR_W-1:0]          mm_addr,
  input  logic                          mm_wr,
  input  logic [31:0]                   mm_wdata,
  input  logic                          mm_rd,
  output logic [31:0]                   mm_rdata,
  output port_entry_t [NUM_CH-1:0]      table_o
);
  port_entry_t [NUM_CH-1:0] tbl_q;
  logic [31:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q <= '0;
    end else if (mm_wr) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (mm_addr == MM_ADDR_W'(i)) begin
          tbl_q[i].en   <= mm_wdata[16];
          tbl_q[i].port <= mm_wdata[15:0];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (mm_addr == MM_ADDR_W'(i)) rd_mux = {15'd0, tbl_q[i].en, tbl_q[i].port};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        mm_rdata <= '0;
    else if (mm_rd) mm_rdata <= rd_mux;
  end

  assign table_o = tbl_q;

  // R2
  rsvd_addr_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mm_rd && (int'(mm_addr) >= NUM_CH)) |=> (mm_rdata == 32'd0));
endmodule

// File: rtl/udp_demux_classify.sv
module udp_demux_classify
  import udp_demux_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc,
  input  logic                     sop,
  input  logic                     eop,
  input  logic [WORD_W-1:0]        data,
  input  port_entry_t [NUM_CH-1:0] table_i,
  output logic                     dec_push,
  output logic [SEL_W-1:0]         dec_sel
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]         wcnt_q, idx;
  logic [15:0]              etype_q;
  logic [7:0]               vihl_q, proto_q;
  logic                     decided_q, decided_eff, udp_ok;
  port_entry_t [NUM_CH-1:0] snap_q;

  assign idx         = sop ? '0 : wcnt_q;
  assign decided_eff = sop ? 1'b0 : decided_q;
  assign udp_ok      = (etype_q == ETYPE_IPV4) && (vihl_q == VER_IHL_PLAIN) && (proto_q == PROTO_UDP);
  assign dec_push    = acc && !decided_eff && ((idx == CNT_W'(PORT_WORD)) || eop);

  always_comb begin
    dec_sel = SEL_W'(NUM_CH);
    if ((idx == CNT_W'(PORT_WORD)) && udp_ok) begin
      for (int i = NUM_CH - 1; i >= 0; i--) begin
        if (snap_q[i].en && (snap_q[i].port == data[31:16])) dec_sel = SEL_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q    <= '0;
      etype_q   <= '0;
      vihl_q    <= '0;
      proto_q   <= '0;
      decided_q <= 1'b0;
      snap_q    <= '0;
    end else if (acc) begin
      if (sop) snap_q <= table_i;
      if (eop)                 wcnt_q <= '0;
      else if (idx != CNT_MAX) wcnt_q <= idx + 1'b1;
      if (idx == CNT_W'(ETYPE_WORD)) begin
        etype_q <= data[31:16];
        vihl_q  <= data[15:8];
      end
      if (idx == CNT_W'(PROTO_WORD)) proto_q <= data[7:0];
      decided_q <= eop ? 1'b0 : (decided_eff || dec_push);
    end
  end

  // R6
  one_decision_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !sop && decided_q) |-> !dec_push);
  // R8
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !sop && !eop) |=> (snap_q == $past(snap_q)));
endmodule

// File: rtl/udp_stream_demux.sv
module udp_stream_demux
  import udp_demux_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int MM_ADDR_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [31:0]          s_data,
  input  logic                 s_sop,
  input  logic                 s_eop,
  input  logic                 s_valid,
  output logic                 s_ready,
  output logic [31:0]          m_data,
  output logic                 m_sop,
  output logic                 m_eop,
  output logic [NUM_CH:0]      m_valid,
  input  logic [NUM_CH:0]      m_ready,
  input  logic [MM_ADDR_W-1:0] mm_addr,
  input  logic                 mm_wr,
  input  logic [31:0]          mm_wdata,
  input  logic                 mm_rd,
  output logic [31:0]          mm_rdata
);
  localparam int OUT_N  = NUM_CH + 1;
  localparam int SEL_W  = $clog2(OUT_N);
  localparam int WORD_E = WORD_W + 2;

  port_entry_t [NUM_CH-1:0] tbl;
  logic              acc, dec_push;
  logic [SEL_W-1:0]  dec_sel, q_sel;
  logic              d_full, d_empty, q_full, q_empty;
  logic [WORD_E-1:0] d_head;
  logic              head_ok, can_load, pop;

  udp_demux_regs #(.NUM_CH(NUM_CH), .MM_ADDR_W(MM_ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .mm_addr(mm_addr), .mm_wr(mm_wr), .mm_wdata(mm_wdata),
    .mm_rd(mm_rd), .mm_rdata(mm_rdata), .table_o(tbl)
  );

  assign s_ready = !d_full && !q_full;
  assign acc     = s_valid && s_ready;

  udp_demux_classify #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_classify (
    .clk(clk), .rst(rst), .acc(acc), .sop(s_sop), .eop(s_eop), .data(s_data),
    .table_i(tbl), .dec_push(dec_push), .dec_sel(dec_sel)
  );

  udp_demux_fifo #(.W(WORD_E), .DEPTH(FIFO_DEPTH)) u_word_fifo (
    .clk(clk), .rst(rst), .wr(acc), .wdata({s_sop, s_eop, s_data}),
    .rd(pop), .rdata(d_head), .full(d_full), .empty(d_empty)
  );

  udp_demux_fifo #(.W(SEL_W), .DEPTH(FIFO_DEPTH)) u_dec_fifo (
    .clk(clk), .rst(rst), .wr(dec_push), .wdata(dec_sel),
    .rd(pop && d_head[WORD_W]), .rdata(q_sel), .full(q_full), .empty(q_empty)
  );

  assign head_ok  = !d_empty && !q_empty;
  assign can_load = ((m_valid & ~m_ready) == '0);
  assign pop      = can_load && head_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= '0;
      m_data  <= '0;
      m_sop   <= 1'b0;
      m_eop   <= 1'b0;
    end else if (can_load) begin
      m_valid <= head_ok ? (OUT_N'(1) << q_sel) : '0;
      if (head_ok) {m_sop, m_eop, m_data} <= d_head;
    end
  end

  // Frame tracking used only by the checks below
  logic            fire, in_frame_q;
  logic [NUM_CH:0] frame_ch_q;
  assign fire = |(m_valid & m_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      frame_ch_q <= '0;
    end else if (fire) begin
      in_frame_q <= !m_eop;
      frame_ch_q <= m_valid;
    end
  end

  // R9
  out_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(m_valid));
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|(m_valid & ~m_ready)) |=> ($stable(m_valid) && $stable(m_data) && $stable(m_sop) && $stable(m_eop)));
  // R6
  frame_whole_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && in_frame_q) |-> ((m_valid == frame_ch_q) && !m_sop));
  // R6
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !in_frame_q) |-> m_sop);
endmodule

// File: tb/udp_stream_demux_bench.sv
`timescale 1ns/1ps
module udp_stream_demux_bench;
  localparam int NUM_CH = 4;
  localparam int FIFO_DEPTH = 16;
  localparam int MM_ADDR_W = 4;

  logic clk = 0, rst = 1;
  logic [31:0] s_data = '0;
  logic s_sop = 0, s_eop = 0, s_valid = 0, s_ready;
  logic [31:0] m_data;
  logic m_sop, m_eop;
  logic [NUM_CH:0] m_valid, m_ready = '0;
  logic [MM_ADDR_W-1:0] mm_addr = '0;
  logic mm_wr = 0, mm_rd = 0;
  logic [31:0] mm_wdata = '0, mm_rdata;

  always #2 clk = ~clk;

  udp_stream_demux #(.NUM_CH(NUM_CH), .FIFO_DEPTH(FIFO_DEPTH), .MM_ADDR_W(MM_ADDR_W)) u_udp_stream_demux (
    .clk(clk), .rst(rst), .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop), .s_valid(s_valid),
    .s_ready(s_ready), .m_data(m_data), .m_sop(m_sop), .m_eop(m_eop), .m_valid(m_valid),
    .m_ready(m_ready), .mm_addr(mm_addr), .mm_wr(mm_wr), .mm_wdata(mm_wdata), .mm_rd(mm_rd),
    .mm_rdata(mm_rdata)
  );

  int checks = 0, fails = 0, acc_cnt = 0;
  string cur_req = "R1";
  bit stall = 0, no_gap = 0, running = 0;
  logic [33:0] exp_q [NUM_CH+1][$];
  logic [16:0] mcfg [NUM_CH];
  logic [31:0] fw [40];

  task automatic check(string req, logic [63:0] got, logic [63:0] exp, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Output monitor: randomize ready, then score the handshake due at the next edge
  always @(negedge clk) begin
    if (running) begin
      for (int c = 0; c <= NUM_CH; c++) m_ready[c] = stall ? 1'b0 : (($urandom % 4) != 0);
      check("R9", 64'($countones(m_valid) <= 1), 64'd1, "at most one valid");
      for (int c = 0; c <= NUM_CH; c++) begin
        if (m_valid[c] && m_ready[c]) begin
          if (exp_q[c].size() == 0) begin
            check("R6", 64'({m_sop, m_eop, m_data}), 64'h3_0000_0000 | 64'hdead, $sformatf("unexpected word on out%0d", c));
          end else begin
            check(cur_req, 64'({m_sop, m_eop, m_data}), 64'(exp_q[c].pop_front()), $sformatf("word on out%0d", c));
          end
        end
      end
    end
  end

  task automatic put_word(input logic [31:0] d, input logic sop, input logic eop);
    int gap = no_gap ? 0 : $urandom_range(0, 2);
    repeat (gap) @(negedge clk);
    s_valid = 1; s_data = d; s_sop = sop; s_eop = eop;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0; s_sop = 0; s_eop = 0;
    acc_cnt++;
  endtask

  task automatic mm_write(input int a, input logic [31:0] d);
    mm_addr = MM_ADDR_W'(a); mm_wdata = d; mm_wr = 1;
    @(negedge clk);
    mm_wr = 0;
    if (a < NUM_CH) mcfg[a] = d[16:0];
  endtask

  task automatic mm_read(input int a, output logic [31:0] d);
    mm_addr = MM_ADDR_W'(a); mm_rd = 1;
    @(negedge clk);
    mm_rd = 0;
    d = mm_rdata;
  endtask

  // kind: 0 udp, 1 non-ip ethertype, 2 ip non-udp, 3 other header length byte
  task automatic build(input int kind, input logic [15:0] port, input int n);
    for (int k = 0; k < n; k++) fw[k] = $urandom;
    if (n > 3) fw[3][31:8] = {16'h0800, 8'h45};
    if (n > 5) fw[5][7:0] = 8'd17;
    if (n > 9) fw[9][31:16] = port;
    if (kind == 1 && n > 3) fw[3][31:16] = 16'h86dd;
    if (kind == 2 && n > 5) fw[5][7:0] = 8'd6;
    if (kind == 3 && n > 3) fw[3][15:8] = 8'h46;
  endtask

  function automatic int model_sel(input int n);
    if (n < 10) return NUM_CH;
    if (fw[3][31:16] != 16'h0800 || fw[3][15:8] != 8'h45 || fw[5][7:0] != 8'd17) return NUM_CH;
    for (int i = 0; i < NUM_CH; i++)
      if (mcfg[i][16] && mcfg[i][15:0] == fw[9][31:16]) return i;
    return NUM_CH;
  endfunction

  task automatic expect_frame(input int n);
    int sel = model_sel(n);
    for (int k = 0; k < n; k++) exp_q[sel].push_back({k == 0, k == n - 1, fw[k]});
  endtask

  task automatic send_range(input int lo, input int hi, input int n);
    for (int k = lo; k < hi; k++) put_word(fw[k], k == 0, k == n - 1);
  endtask

  task automatic send_frame(input int n);
    expect_frame(n);
    send_range(0, n, n);
  endtask

  task automatic drain();
    int left;
    for (int t = 0; t < 4000; t++) begin
      left = 0;
      for (int c = 0; c <= NUM_CH; c++) left += exp_q[c].size();
      if (left == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] rv;
    logic [15:0] pool [6];
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM_CH; i++) mcfg[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", 64'(m_valid), 64'd0, "valid after reset");
    check("R1", 64'(s_ready), 64'd1, "s_ready after reset");
    for (int i = 0; i < NUM_CH; i++) begin
      mm_read(i, rv);
      check("R1", 64'(rv), 64'd0, $sformatf("entry %0d after reset", i));
    end
    running = 1;

    // R2 register format and reserved space
    mm_write(2, 32'hffff_ffff);
    mm_read(2, rv);
    check("R2", 64'(rv), 64'h1ffff, "masked entry readback");
    mm_write(NUM_CH, 32'h0001_1234);
    mm_write(15, 32'h0001_5678);
    mm_read(NUM_CH, rv);
    check("R2", 64'(rv), 64'd0, "unmapped address reads zero");
    mm_read(15, rv);
    check("R2", 64'(rv), 64'd0, "top address reads zero");
    for (int i = 0; i < NUM_CH; i++) begin
      mm_read(i, rv);
      check("R2", 64'(rv), 64'(mcfg[i]), $sformatf("entry %0d untouched", i));
    end

    // R3 directed match; R4 length boundary and rejects
    mm_write(0, 32'h0001_1111);
    mm_write(1, 32'h0000_2222);
    mm_write(2, 32'h0001_2222);
    mm_write(3, 32'h0001_3333);
    cur_req = "R3";
    build(0, 16'h2222, 10); send_frame(10);
    build(0, 16'h3333, 15); send_frame(15);
    cur_req = "R4";
    build(0, 16'h1111, 9);  send_frame(9);
    build(1, 16'h1111, 12); send_frame(12);
    build(2, 16'h1111, 12); send_frame(12);
    build(3, 16'h1111, 12); send_frame(12);
    build(0, 16'h4444, 12); send_frame(12);
    build(0, 16'h1111, 1);  send_frame(1);
    // R5 duplicate ports
    cur_req = "R5";
    mm_write(1, 32'h0001_3333);
    build(0, 16'h3333, 11); send_frame(11);
    check("R5", 64'(model_sel(11)), 64'd1, "model picks lowest");
    drain();

    // R8 write lands mid-frame, both directions
    cur_req = "R8";
    mm_write(0, 32'h0001_5000);
    build(0, 16'h5000, 12); expect_frame(12);
    send_range(0, 5, 12);
    mm_write(0, 32'h0000_5000);
    send_range(5, 12, 12);
    build(0, 16'h5000, 12); send_frame(12);
    build(0, 16'h5000, 12); expect_frame(12);
    send_range(0, 4, 12);
    mm_write(0, 32'h0001_5000);
    send_range(4, 12, 12);
    build(0, 16'h5000, 12); send_frame(12);
    drain();

    // R7 full stall: buffer plus output register
    cur_req = "R7";
    stall = 1; no_gap = 1;
    @(negedge clk);
    acc_cnt = 0;
    build(0, 16'h5000, 30); expect_frame(30);
    fork
      send_range(0, 30, 30);
      begin
        repeat (200) @(negedge clk);
        check("R7", 64'(acc_cnt), 64'(FIFO_DEPTH + 1), "words accepted while stalled");
        check("R7", 64'(s_ready), 64'd0, "s_ready low while stalled");
        stall = 0;
      end
    join
    no_gap = 0;
    drain();

    // Random traffic
    cur_req = "R6";
    pool[0] = 16'h1000; pool[1] = 16'h1001; pool[2] = 16'h1002;
    pool[3] = 16'h1003; pool[4] = 16'h1004; pool[5] = 16'hbeef;
    for (int f = 0; f < 150; f++) begin
      int kind, n, r;
      if (f % 10 == 0)
        for (int i = 0; i < NUM_CH; i++)
          mm_write(i, {15'd0, 1'($urandom_range(0, 3) != 0), pool[$urandom_range(0, 4)]});
      r = $urandom_range(0, 9);
      kind = (r < 6) ? 0 : (r - 6);
      n = (r == 9) ? $urandom_range(1, 9) : $urandom_range(10, 24);
      if (r == 9) kind = 0;
      build(kind, pool[$urandom_range(0, 5)], n);
      send_frame(n);
    end
    drain();
    repeat (10) @(negedge clk);
    for (int c = 0; c <= NUM_CH; c++)
      check("R6", 64'(exp_q[c].size()), 64'd0, $sformatf("words left for out%0d", c));
    finish_run();
  end
endmodule